// File: doc/BRIEF.md
# Dual-Master Selector Interrupt Aggregator

This block produces the two active-low interrupt requests that a two-port bus master selector presents upstream, one per master port. It collects several interrupt causes, latches each one per port, and drives a port's request line low (modelled as an output enable) while any unmasked latched cause of that port is pending. The causes are a downstream interrupt line shared by both ports, the loss of bus ownership by a master, the completion of a bus initialization requested by a port, and a channel switch made while the downstream bus is in the middle of a transfer.

The mid-transfer detector watches the raw downstream clock and data lines through a two-flop synchronizer and tracks START and STOP conditions to know whether the bus is busy. When automatic initialization is not in use and ownership is handed to a master while the bus is busy, that new master is told it must recover the bus itself. Two test inputs per port force request lines without regard to masks: one acts on the port itself, the other on the opposite port. Software clears a port's latched causes with a one-cycle clear strobe.

Top module: `msel_irq_agg`

## Requirements
- R1: After reset both request enables `irq_oe` are 0, no cause is latched and `bus_busy` is 0.
- R2: While `ds_int_n` is low and cause 0 (downstream) is unmasked for a port, that port's `irq_oe` is 1 from the third clock edge after the input falls onward, and the cause stays latched while the input stays low even if cleared.
- R3: Mask bit `mask[p*4+c]` (cause c: 0 downstream, 1 ownership lost, 2 init done, 3 mid-transfer switch) blocks both capture and output of that cause on port p; a cause whose event occurred while masked is discarded and does not appear when the mask is later removed.
- R4: An `own_chg` pulse with a valid previous owner latches cause 1 on the previous owner's port unless the new owner is valid and equal to it; the request is visible after the edge that samples the pulse.
- R5: An `init_done` pulse latches cause 2 on the port given by `init_id`, unless that port masks cause 2.
- R6: `bus_busy` rises after a START (SDA falls while SCL is high) and falls after a STOP (SDA rises while SCL is high), each three edges after the raw change; SDA changes while SCL is low change nothing. An `own_chg` pulse to a valid new owner while `bus_busy` is 1 latches cause 3 on the new owner's port, and does not when the bus is idle.
- R7: A `clr[p]` pulse empties port p's latched causes at the next edge, except a cause whose event arrives in that same cycle, which is latched.
- R8: While `autoinit_en` is 1, cause 3 is never latched.
- R9: When cause 3 is masked on the new owner's port, a mid-transfer switch raises no request there.
- R10: `test_self[p]` forces `irq_oe[p]` to 1 and `test_other[p]` forces the opposite port's `irq_oe` to 1, combinationally and regardless of masks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ds_int_n | input | 1 | Downstream interrupt, active low, asynchronous |
| scl_in | input | 1 | Raw downstream clock line |
| sda_in | input | 1 | Raw downstream data line |
| own_chg | input | 1 | One-cycle ownership change event |
| own_prev_vld | input | 1 | A previous owner existed |
| own_prev_id | input | 1 | Previous owner port |
| own_new_vld | input | 1 | A new owner is selected |
| own_new_id | input | 1 | New owner port |
| init_done | input | 1 | One-cycle bus initialization completion |
| init_id | input | 1 | Port that requested the initialization |
| autoinit_en | input | 1 | Automatic initialization in use (disables mid-transfer cause) |
| mask | input | 8 | Per-port cause masks, bit p*4+c |
| test_self | input | 2 | Force own port's request |
| test_other | input | 2 | Force opposite port's request |
| clr | input | 2 | Per-port clear strobe |
| irq_oe | output | 2 | Open-drain pull-low enables, 1 = request line driven low |
| bus_busy | output | 1 | Downstream bus between START and STOP |

## Verification
The bench builds the block with its default two-stage synchronizer, which fixes the START, STOP and downstream-interrupt latency at three edges and lets the bench place its samples exactly. With two ports, every cause can be steered to either port or to both at once, so the sequences cover the lost-owner and new-owner requests landing on opposite ports in one cycle, the collision of a clear with a new event, and the interplay of masks, automatic initialization and the test forces.

// File: rtl/msel_irq_pkg.sv
package msel_irq_pkg;
  localparam int NPORT  = 2;
  localparam int PIDW   = 1;
  localparam int NCAUSE = 4;
  localparam int MASKW  = NPORT * NCAUSE;

  typedef enum int unsigned {
    C_DSINT = 0,
    C_LOST  = 1,
    C_INIT  = 2,
    C_SENSE = 3
  } cause_e;

  typedef logic [NCAUSE-1:0] cause_vec_t;

  function automatic logic f_start(input logic sda_old, input logic sda_now,
                                   input logic scl_old, input logic scl_now);
    return sda_old & ~sda_now & scl_old & scl_now;
  endfunction

  function automatic logic f_stop(input logic sda_old, input logic sda_now,
                                  input logic scl_old, input logic scl_now);
    return ~sda_old & sda_now & scl_old & scl_now;
  endfunction

  function automatic logic f_lost(input logic prev_vld, input logic [PIDW-1:0] prev_id,
                                  input logic new_vld, input logic [PIDW-1:0] new_id,
                                  input logic [PIDW-1:0] port);
    return prev_vld && (prev_id == port) && !(new_vld && (new_id == prev_id));
  endfunction

  function automatic logic f_gained(input logic new_vld, input logic [PIDW-1:0] new_id,
                                    input logic [PIDW-1:0] port);
    return new_vld && (new_id == port);
  endfunction

  function automatic cause_vec_t f_capture(input cause_vec_t pend, input cause_vec_t set,
                                           input cause_vec_t mask, input logic clr);
    return (pend & ~({NCAUSE{clr}})) | (set & ~mask);
  endfunction

  function automatic logic f_drive(input cause_vec_t pend, input cause_vec_t mask,
                                   input logic t_self, input logic t_other);
    return (|(pend & ~mask)) | t_self | t_other;
  endfunction
endpackage

// File: rtl/msel_sync.sv
module msel_sync #(
  parameter int            W       = 1,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/msel_bus_sense.sv
module msel_bus_sense
  import msel_irq_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic busy,
  output logic start_ev,
  output logic stop_ev
);
  logic [1:0] lines_now;
  logic       scl_old, sda_old;
  logic       scl_now, sda_now;

  msel_sync #(.W(2), .STAGES(STAGES), .RST_VAL(2'b11)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({scl_raw, sda_raw}),
    .q    (lines_now)
  );

  assign scl_now = lines_now[1];
  assign sda_now = lines_now[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_old <= 1'b1;
      sda_old <= 1'b1;
    end else begin
      scl_old <= scl_now;
      sda_old <= sda_now;
    end
  end

  assign start_ev = f_start(sda_old, sda_now, scl_old, scl_now);
  assign stop_ev  = f_stop(sda_old, sda_now, scl_old, scl_now);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        busy <= 1'b0;
    else if (start_ev) busy <= 1'b1;
    else if (stop_ev)  busy <= 1'b0;
  end

  // R6: a START makes the bus busy, a STOP makes it idle
  a_r6_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> busy);
  a_r6_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !busy);
  a_r6_busy_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_ev));
endmodule

// File: rtl/msel_irq_port.sv
module msel_irq_port
  import msel_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  cause_vec_t set_vec,
  input  cause_vec_t mask,
  input  logic       clr,
  input  logic       t_self,
  input  logic       t_other,
  output cause_vec_t pend,
  output logic       irq_oe
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= f_capture(pend, set_vec, mask, clr);
  end

  assign irq_oe = f_drive(pend, mask, t_self, t_other);

  // R7: a clear with no new event empties the port
  a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && (set_vec == '0)) |=> (pend == '0));

  for (genvar c = 0; c < NCAUSE; c++) begin : g_cause
    // R3: a cause only appears from an unmasked event
    a_r3_capture_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend[c]) |-> $past(set_vec[c] & ~mask[c]));
    // R7: an event arriving with a clear still lands
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (set_vec[c] && !mask[c]) |=> pend[c]);
  end
endmodule

// File: rtl/msel_irq_agg.sv
module msel_irq_agg
  import msel_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ds_int_n,
  input  logic                  scl_in,
  input  logic                  sda_in,
  input  logic                  own_chg,
  input  logic                  own_prev_vld,
  input  logic [PIDW-1:0]       own_prev_id,
  input  logic                  own_new_vld,
  input  logic [PIDW-1:0]       own_new_id,
  input  logic                  init_done,
  input  logic [PIDW-1:0]       init_id,
  input  logic                  autoinit_en,
  input  logic [MASKW-1:0]      mask,
  input  logic [NPORT-1:0]      test_self,
  input  logic [NPORT-1:0]      test_other,
  input  logic [NPORT-1:0]      clr,
  output logic [NPORT-1:0]      irq_oe,
  output logic                  bus_busy
);
  logic       ds_sync_n;
  logic       start_ev, stop_ev;
  logic       sense_arm;
  cause_vec_t set_vec  [NPORT];
  cause_vec_t mask_vec [NPORT];
  cause_vec_t pend_vec [NPORT];

  msel_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ds_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (ds_int_n),
    .q    (ds_sync_n)
  );

  msel_bus_sense #(.STAGES(SYNC_STAGES)) u_sense (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_raw (scl_in),
    .sda_raw (sda_in),
    .busy    (bus_busy),
    .start_ev(start_ev),
    .stop_ev (stop_ev)
  );

  assign sense_arm = own_chg && !autoinit_en && bus_busy;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam logic [PIDW-1:0] PID = PIDW'(p);

    assign mask_vec[p] = mask[p*NCAUSE +: NCAUSE];

    always_comb begin
      set_vec[p]          = '0;
      set_vec[p][C_DSINT] = !ds_sync_n;
      set_vec[p][C_LOST]  = own_chg && f_lost(own_prev_vld, own_prev_id,
                                              own_new_vld, own_new_id, PID);
      set_vec[p][C_INIT]  = init_done && (init_id == PID);
      set_vec[p][C_SENSE] = sense_arm && f_gained(own_new_vld, own_new_id, PID);
    end

    msel_irq_port u_port (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_vec(set_vec[p]),
      .mask   (mask_vec[p]),
      .clr    (clr[p]),
      .t_self (test_self[p]),
      .t_other(test_other[NPORT-1-p]),
      .pend   (pend_vec[p]),
      .irq_oe (irq_oe[p])
    );

    // R4: the master that lost the bus is told so
    a_r4_lost_notify: assert property (@(posedge clk) disable iff (!rst_n)
      (own_chg && own_prev_vld && (own_prev_id == PID) &&
       !(own_new_vld && (own_new_id == PID)) && !mask[p*NCAUSE + C_LOST])
      |=> (irq_oe[p] || mask[p*NCAUSE + C_LOST]));
    // R8: with automatic initialization the mid-transfer cause stays clear
    a_r8_no_sense_autoinit: assert property (@(posedge clk) disable iff (!rst_n)
      (autoinit_en && !pend_vec[p][C_SENSE]) |=> !pend_vec[p][C_SENSE]);
    // R5: an init completion reaches its requester
    a_r5_init_notify: assert property (@(posedge clk) disable iff (!rst_n)
      (init_done && (init_id == PID) && !mask[p*NCAUSE + C_INIT])
      |=> pend_vec[p][C_INIT]);
  end
endmodule

// File: tb/msel_irq_agg_bench.sv
module msel_irq_agg_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ds_int_n = 1'b1, scl_in = 1'b1, sda_in = 1'b1;
  logic       own_chg = 1'b0, own_prev_vld = 1'b0, own_new_vld = 1'b0;
  logic [0:0] own_prev_id = '0, own_new_id = '0, init_id = '0;
  logic       init_done = 1'b0, autoinit_en = 1'b0;
  logic [7:0] mask = '0;
  logic [1:0] test_self = '0, test_other = '0, clr = '0;
  logic [1:0] irq_oe;
  logic       bus_busy;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  typedef struct {
    string      tag;
    logic [1:0] oe;
    logic       busy;
  } exp_t;
  exp_t sbq[$];

  always #2 clk = ~clk;

  msel_irq_agg u_msel_irq_agg (
    .clk(clk), .rst_n(rst_n), .ds_int_n(ds_int_n), .scl_in(scl_in), .sda_in(sda_in),
    .own_chg(own_chg), .own_prev_vld(own_prev_vld), .own_prev_id(own_prev_id),
    .own_new_vld(own_new_vld), .own_new_id(own_new_id), .init_done(init_done),
    .init_id(init_id), .autoinit_en(autoinit_en), .mask(mask), .test_self(test_self),
    .test_other(test_other), .clr(clr), .irq_oe(irq_oe), .bus_busy(bus_busy)
  );

  // monitor: pops expected items and compares at the falling edge
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      n_checks++;
      if (irq_oe !== e.oe || bus_busy !== e.busy) begin
        n_fail++;
        $display("FAIL %s: irq_oe=%b busy=%b expected irq_oe=%b busy=%b",
                 e.tag, irq_oe, bus_busy, e.oe, e.busy);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic expect_now(input string tag, input logic [1:0] oe, input logic busy);
    exp_t e;
    e.tag = tag; e.oe = oe; e.busy = busy;
    sbq.push_back(e);
    @(negedge clk);
    step(1);
  endtask

  task automatic pulse_own(input logic pv, input logic pid, input logic nv, input logic nid);
    own_chg = 1'b1; own_prev_vld = pv; own_prev_id = pid;
    own_new_vld = nv; own_new_id = nid;
    step(1);
    own_chg = 1'b0;
  endtask

  task automatic pulse_clr(input logic [1:0] which);
    clr = which;
    step(1);
    clr = '0;
  endtask

  task automatic pulse_init(input logic id);
    init_done = 1'b1; init_id = id;
    step(1);
    init_done = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(2);
    expect_now("R1 reset state", 2'b00, 1'b0);

    // R2 downstream interrupt on both ports
    ds_int_n = 1'b0; step(5);
    expect_now("R2 downstream both ports", 2'b11, 1'b0);
    pulse_clr(2'b11);
    expect_now("R7 level cause relatched", 2'b11, 1'b0);
    ds_int_n = 1'b1; step(5);
    pulse_clr(2'b11);
    expect_now("R7 clear empties", 2'b00, 1'b0);

    // R3 mask port 1 downstream
    mask[4] = 1'b1;
    ds_int_n = 1'b0; step(5);
    expect_now("R3 masked port1", 2'b01, 1'b0);
    ds_int_n = 1'b1; step(5);
    pulse_clr(2'b11);
    mask = '0; step(1);
    expect_now("R3 masked event discarded", 2'b00, 1'b0);

    // R4 ownership lost
    pulse_own(1'b1, 1'b0, 1'b1, 1'b1);
    expect_now("R4 lost to port0", 2'b01, 1'b0);
    pulse_clr(2'b01);
    expect_now("R7 clear port0", 2'b00, 1'b0);
    pulse_own(1'b1, 1'b1, 1'b1, 1'b1);
    expect_now("R4 same owner no notify", 2'b00, 1'b0);
    pulse_own(1'b1, 1'b1, 1'b0, 1'b0);
    expect_now("R4 release notifies port1", 2'b10, 1'b0);
    pulse_clr(2'b10);

    // R5 init done
    pulse_init(1'b1);
    expect_now("R5 init done port1", 2'b10, 1'b0);
    pulse_clr(2'b10);
    mask[2] = 1'b1;
    pulse_init(1'b0);
    expect_now("R5 init masked port0", 2'b00, 1'b0);
    mask = '0;

    // R6 sensor: SDA change while SCL low is not a START
    scl_in = 1'b0; step(1);
    sda_in = 1'b0; step(1);
    scl_in = 1'b1; step(5);
    expect_now("R6 no start while scl low", 2'b00, 1'b0);
    sda_in = 1'b1; step(5);
    expect_now("R6 stop on idle bus", 2'b00, 1'b0);
    sda_in = 1'b0; step(5);
    expect_now("R6 start sets busy", 2'b00, 1'b1);
    pulse_own(1'b1, 1'b0, 1'b1, 1'b1);
    expect_now("R6 mid-transfer switch plus R4 lost", 2'b11, 1'b1);
    pulse_clr(2'b11);
    autoinit_en = 1'b1;
    pulse_own(1'b0, 1'b0, 1'b1, 1'b0);
    expect_now("R8 autoinit suppresses sensor", 2'b00, 1'b1);
    autoinit_en = 1'b0;
    mask[7] = 1'b1;
    pulse_own(1'b0, 1'b0, 1'b1, 1'b1);
    expect_now("R9 sensor masked", 2'b00, 1'b1);
    mask = '0;
    pulse_own(1'b0, 1'b0, 1'b1, 1'b1);
    expect_now("R9 sensor unmasked", 2'b10, 1'b1);
    pulse_clr(2'b10);
    sda_in = 1'b1; step(5);
    expect_now("R6 stop clears busy", 2'b00, 1'b0);
    pulse_own(1'b0, 1'b0, 1'b1, 1'b1);
    expect_now("R6 idle switch no sensor", 2'b00, 1'b0);

    // R10 test forces
    test_self = 2'b01; step(1);
    expect_now("R10 self force port0", 2'b01, 1'b0);
    test_self = 2'b00; test_other = 2'b01; step(1);
    expect_now("R10 other force port1", 2'b10, 1'b0);
    mask = 8'hFF; ds_int_n = 1'b0; step(5);
    expect_now("R10 force ignores masks", 2'b10, 1'b0);
    test_other = 2'b00; ds_int_n = 1'b1; step(5);
    expect_now("R3 all masked silent", 2'b00, 1'b0);
    mask = '0; step(1);

    // R7 event and clear in the same cycle
    clr = 2'b01;
    pulse_own(1'b1, 1'b0, 1'b0, 1'b0);
    clr = 2'b00;
    expect_now("R7 event beats clear", 2'b01, 1'b0);
    pulse_clr(2'b01);
    expect_now("R7 final clear", 2'b00, 1'b0);

    step(2);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule